// File: doc/BRIEF.md
# Single-wire pulse-coded bit codec

This block sends and receives bytes over one open-drain wire that a host and a device share in half-duplex. Every bit opens with a short low pulse. A one is that pulse alone, and the line stays high for the rest of the bit period. A zero adds a high gap and then a second short low pulse inside the same bit period. Bytes go out and come in least-significant bit first.

Bytes to send arrive on a valid/ready stream. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` then stays low until the last bit period of that byte has ended, so the source must hold its next byte until `tx_ready` rises again. Received bytes leave on `rx_data` with a one-cycle `rx_valid` strobe. The receive side has no back-pressure: a byte that the consumer misses is lost.

The line input is expected to be glitch-filtered already; the block synchronises it to `clk` before use. While the block transmits, the receiver ignores the line, so it never decodes the echo of its own pulses. After any line activity from the far side, the transmitter waits a fixed turnaround gap before it starts a new byte. All timing is in clock cycles and is set by parameters. The defaults suit a 50 MHz clock: a pulse of about 4.3 µs, a bit period of 39 µs, a zero-detect window of 20 µs and a turnaround gap of 60 µs.

Top module: `swb_codec`

## Requirements
- R1: After reset, `tx_ready` is 1, `io_drive_low` is 0 and `rx_valid` is 0.
- R2: Each transmitted bit starts with `io_drive_low` high for exactly PULSE_CYC cycles. A bit of value one has no other low pulse.
- R3: A transmitted zero has a second low pulse of exactly PULSE_CYC cycles. It starts PULSE_CYC+GAP_CYC cycles after the start pulse began.
- R4: Within a byte, bit starts are exactly BIT_CYC cycles apart. The 8 bits go out least-significant first.
- R5: A byte is accepted on an edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 in the cycle after acceptance and stays 0 until the byte's eighth bit period ends.
- R6: `io_drive_low` (1 = pull the wire low, 0 = release it; the block never drives the wire high) is 0 whenever no byte is being sent.
- R7: The receiver starts a bit on a falling edge of the line. If a second falling edge comes within ZWIN_CYC cycles, the bit is 0; otherwise it is 1. Bits are taken least-significant first. After the eighth bit, `rx_data` holds the byte and `rx_valid` is high for one cycle. Far-side pulse widths between PULSE_CYC and 2*PULSE_CYC are accepted.
- R8: No `rx_valid` strobe results from the block's own transmission.
- R9: After each rising edge of the line seen while not transmitting, `tx_ready` stays 0 for at least TURN_CYC cycles and then returns to 1.
- R10: If a partly received byte sees no new start edge for RXTMO_CYC cycles, the partial bits are dropped. The next byte is then decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Block accepts a byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data is new |
| io_in | input | 1 | Filtered level of the wire |
| io_drive_low | output | 1 | 1 pulls the wire low, 0 releases it |

## Verification
The hardest situation to reach is a receive byte cut off partway, followed by a clean byte. The receiver must drop the stale bits rather than mix them into the next byte. The bench's far-side model sends only three bits, stays silent past the timeout, and then sends a full byte whose value would change if any old bit survived. The turnaround rule is also checked at exact cycle offsets from the last far-side release. Far-side pulse widths and gaps are drawn at random inside the accepted range.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef logic [7:0] swb_byte_t;

  // width of a counter that must hold values 0..n
  function automatic int swb_cw(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/swb_tx.sv
module swb_tx
  import swb_pkg::*;
#(
  parameter int PULSE_CYC = 217,
  parameter int GAP_CYC   = 217,
  parameter int BIT_CYC   = 1950
) (
  input  logic      clk,
  input  logic      rst_n,
  input  swb_byte_t data,
  input  logic      valid,
  input  logic      gap_ok,
  output logic      ready,
  output logic      busy,
  output logic      drive_low
);
  localparam int CW = swb_cw(BIT_CYC);
  localparam logic [CW-1:0] P_C    = CW'(PULSE_CYC);
  localparam logic [CW-1:0] Z_BEG  = CW'(PULSE_CYC + GAP_CYC);
  localparam logic [CW-1:0] Z_END  = CW'(2 * PULSE_CYC + GAP_CYC);
  localparam logic [CW-1:0] B_LAST = CW'(BIT_CYC - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  swb_byte_t     sh;

  assign ready = !busy && gap_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
    end else if (!busy) begin
      if (valid && ready) begin
        busy <= 1'b1;
        sh   <= data;
        cnt  <= '0;
        idx  <= '0;
      end
    end else if (cnt == B_LAST) begin
      cnt <= '0;
      if (idx == 3'd7) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 3'd1;
        sh  <= {1'b0, sh[7:1]};
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    drive_low = 1'b0;
    if (busy) begin
      if (cnt < P_C) drive_low = 1'b1;
      else if (!sh[0] && cnt >= Z_BEG && cnt < Z_END) drive_low = 1'b1;
    end
  end
endmodule

// File: rtl/swb_rx.sv
module swb_rx
  import swb_pkg::*;
#(
  parameter int ZWIN_CYC  = 1000,
  parameter int RXTMO_CYC = 4000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      io_in,
  input  logic      en,
  output logic      line_rise,
  output swb_byte_t rx_data,
  output logic      rx_valid
);
  localparam int WCW = swb_cw(ZWIN_CYC);
  localparam int TCW = swb_cw(RXTMO_CYC);
  localparam logic [WCW-1:0] W_LAST = WCW'(ZWIN_CYC - 1);
  localparam logic [TCW-1:0] T_LIM  = TCW'(RXTMO_CYC);

  logic [2:0]     sync;
  logic           fall;
  logic           in_bit;
  logic           second;
  logic           bitval;
  logic [WCW-1:0] wcnt;
  logic [TCW-1:0] tcnt;
  logic [2:0]     bcnt;
  swb_byte_t      sh;

  assign fall      = en && !sync[1] && sync[2];
  assign line_rise = en && sync[1] && !sync[2];
  assign bitval    = !(second || fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], io_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_bit   <= 1'b0;
      second   <= 1'b0;
      wcnt     <= '0;
      tcnt     <= '0;
      bcnt     <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!en) begin
        in_bit <= 1'b0;
        bcnt   <= '0;
        tcnt   <= '0;
      end else if (!in_bit) begin
        if (fall) begin
          in_bit <= 1'b1;
          second <= 1'b0;
          wcnt   <= '0;
          tcnt   <= '0;
        end else if (bcnt != 3'd0) begin
          if (tcnt == T_LIM) begin
            bcnt <= '0;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end else begin
        if (tcnt != T_LIM) tcnt <= tcnt + 1'b1;
        if (fall) second <= 1'b1;
        if (wcnt == W_LAST) begin
          in_bit <= 1'b0;
          sh     <= {bitval, sh[7:1]};
          bcnt   <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            rx_data  <= {bitval, sh[7:1]};
            rx_valid <= 1'b1;
          end
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swb_gap.sv
module swb_gap
  import swb_pkg::*;
#(
  parameter int TURN_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_rise,
  output logic gap_ok
);
  localparam int QCW = swb_cw(TURN_CYC);
  localparam logic [QCW-1:0] Q_LIM = QCW'(TURN_CYC);

  logic [QCW-1:0] qcnt;

  assign gap_ok = (qcnt == Q_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         qcnt <= Q_LIM;
    else if (line_rise) qcnt <= '0;
    else if (!gap_ok)   qcnt <= qcnt + 1'b1;
  end
endmodule

// File: rtl/swb_codec.sv
module swb_codec
  import swb_pkg::*;
#(
  parameter int PULSE_CYC = 217,
  parameter int GAP_CYC   = 217,
  parameter int BIT_CYC   = 1950,
  parameter int ZWIN_CYC  = 1000,
  parameter int TURN_CYC  = 3000,
  parameter int RXTMO_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       io_in,
  output logic       io_drive_low
);
  logic tx_busy;
  logic gap_ok;
  logic line_rise;

  swb_tx #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC), .BIT_CYC(BIT_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .data(tx_data), .valid(tx_valid),
    .gap_ok(gap_ok), .ready(tx_ready), .busy(tx_busy), .drive_low(io_drive_low)
  );

  swb_rx #(.ZWIN_CYC(ZWIN_CYC), .RXTMO_CYC(RXTMO_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .en(!tx_busy),
    .line_rise(line_rise), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  swb_gap #(.TURN_CYC(TURN_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .line_rise(line_rise), .gap_ok(gap_ok)
  );
endmodule

// File: rtl/swb_codec_chk.sv
module swb_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_busy,
  input logic rx_valid,
  input logic io_drive_low
);
  // R7
  rx_strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R2
  pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_drive_low) |=> io_drive_low);

  // R8
  no_rx_while_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_busy);

  // R5
  busy_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_valid && tx_ready));
endmodule

bind swb_codec swb_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_busy(tx_busy), .rx_valid(rx_valid), .io_drive_low(io_drive_low)
);

// File: tb/sim_swb_codec.sv
module sim_swb_codec;
  localparam int P    = 4;
  localparam int G    = 4;
  localparam int BIT  = 40;
  localparam int ZW   = 20;
  localparam int TURN = 60;
  localparam int TMO  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       io_drive_low;
  logic       dev_low = 1'b0;
  logic       io_in;

  assign io_in = !(io_drive_low || dev_low);

  swb_codec #(.PULSE_CYC(P), .GAP_CYC(G), .BIT_CYC(BIT), .ZWIN_CYC(ZW),
              .TURN_CYC(TURN), .RXTMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .io_in(io_in), .io_drive_low(io_drive_low)
  );

  always #4 clk = !clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nf = 0;
  int fall_t [0:31];
  int run_len = 0;
  logic drv_prev = 1'b0;
  int rx_cnt = 0;
  logic [7:0] rx_last = '0;
  int dev_rel = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line monitor and receive monitor, sampled at the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (io_drive_low && !drv_prev) begin
        if (nf < 32) fall_t[nf] = cyc;
        nf++;
        run_len = 1;
      end else if (io_drive_low) begin
        run_len++;
      end else if (drv_prev) begin
        chk(run_len == P, "R2/R3 low pulse length", run_len, P);
      end
      drv_prev = io_drive_low;
      if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
      end
    end
  end

  task automatic send_tx(input logic [7:0] b);
    int rx0;
    int i;
    int prev;
    logic [7:0] got;
    int zeros;
    while (!tx_ready) @(negedge clk);
    rx0 = rx_cnt;
    nf = 0;
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R5 ready low after accept", tx_ready, 0);
    repeat (8 * BIT - 4) @(negedge clk);
    chk(tx_ready == 1'b0, "R5 ready low during byte", tx_ready, 0);
    repeat (6) @(negedge clk);
    chk(io_drive_low == 1'b0, "R6 idle line released", io_drive_low, 0);
    // decode the captured pulse starts (R2, R3, R4)
    i = 0; prev = 0; got = '0; zeros = 0;
    for (int k = 0; k < 8; k++) begin
      if (i < nf && i < 32) begin
        if (k > 0) chk(fall_t[i] - prev == BIT, "R4 bit period", fall_t[i] - prev, BIT);
        prev = fall_t[i];
        if (i + 1 < nf && i + 1 < 32 && fall_t[i+1] - fall_t[i] == P + G) begin
          got[k] = 1'b0; i += 2; zeros++;
        end else begin
          got[k] = 1'b1; i += 1;
        end
      end
    end
    chk(got == b, "R4 transmitted byte LSB first", got, b);
    chk(nf == 8 + zeros, "R3 pulse count", nf, 8 + zeros);
    chk(rx_cnt == rx0, "R8 no echo decode", rx_cnt - rx0, 0);
  endtask

  task automatic dev_bit(input bit v, input int plen, input int gap);
    int used;
    dev_low = 1'b1;
    repeat (plen) @(negedge clk);
    dev_low = 1'b0;
    dev_rel = cyc;
    used = plen;
    if (!v) begin
      repeat (gap) @(negedge clk);
      dev_low = 1'b1;
      repeat (plen) @(negedge clk);
      dev_low = 1'b0;
      dev_rel = cyc;
      used += gap + plen;
    end
    repeat (BIT - used) @(negedge clk);
  endtask

  task automatic send_dev(input logic [7:0] b, input int plen, input int gap);
    int rx0;
    rx0 = rx_cnt;
    for (int k = 0; k < 8; k++) dev_bit(b[k], plen, gap);
    chk(rx_cnt == rx0 + 1, "R7 one strobe per byte", rx_cnt - rx0, 1);
    chk(rx_last == b, "R7 received byte", rx_last, b);
    chk(tx_ready == 1'b0, "R9 ready held in turnaround", tx_ready, 0);
    while (cyc < dev_rel + TURN) @(negedge clk);
    chk(tx_ready == 1'b0, "R9 ready low at gap end", tx_ready, 0);
    repeat (4) @(negedge clk);
    chk(tx_ready == 1'b1, "R9 ready back after gap", tx_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);
    chk(io_drive_low == 1'b0, "R1 reset drive", io_drive_low, 0);
    chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(io_drive_low == 1'b0, "R6 released while idle", io_drive_low, 0);

    // directed transmit corners
    send_tx(8'h00);
    send_tx(8'hFF);
    send_tx(8'hA5);
    // directed receive corners, shortest and longest far-side pulses
    send_dev(8'h00, 2 * P, G);
    send_dev(8'hFF, P, G);
    send_dev(8'h5A, 2 * P, 2);

    // partial byte then timeout (R10)
    dev_bit(1'b0, P, G);
    dev_bit(1'b1, P, G);
    dev_bit(1'b1, P, G);
    repeat (TMO + 20) @(negedge clk);
    chk(rx_cnt == 3, "R10 no strobe for partial byte", rx_cnt, 3);
    send_dev(8'h3C, P + 1, G);
    chk(rx_cnt == 4, "R10 clean byte after timeout", rx_cnt, 4);

    // random mix
    for (int n = 0; n < 10; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if ($urandom % 2 == 0) send_tx(b);
      else send_dev(b, P + int'($urandom % (P + 1)), 2 + int'($urandom % 5));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule